// File: doc/BRIEF.md
# Non-Overlapping Pulse Output Group

This block drives one four-pin group of a pulse generator. A host loads a staged output pattern, a per-bit enable mask, a transfer-mode bit and a polarity bit. An external timer channel supplies two single-cycle event strobes, called event A and event B. These strobes move the staged pattern into the output data register. In normal mode, event A alone copies every enabled bit. In non-overlapping mode the two edges of a transition are split. Event A drives enabled bits low when their staged value is 0. Event B drives enabled bits high when their staged value is 1. The time between the two events becomes a guard gap, so two complementary outputs are never both active. A registered polarity stage then drives the pins, either directly or inverted.

The block is used with the timer programmed so that event A comes before event B within each period. The host restages the pattern between periods. Bits outside the enable mask keep their value, so other logic can share the group.

Top module: `ppg_nov_group`

## Requirements
- R1: After reset the pins and the output data register are all 0, the mode is normal and the polarity is direct.
- R2: With polarity select 1 (direct), each pin equals its output data bit.
- R3: With polarity select 0 (inverted), each pin equals the complement of its output data bit.
- R4: In normal mode (mode bit 0), event A copies the staged value into every enabled output bit, and event B has no effect.
- R5: In non-overlapping mode (mode bit 1), event A clears each enabled bit whose staged value is 0. Enabled bits whose staged value is 1 are left as they are.
- R6: In non-overlapping mode, event B sets each enabled bit whose staged value is 1. Enabled bits whose staged value is 0 are left as they are.
- R7: In non-overlapping mode, events A and B in the same cycle leave the enabled bits equal to the staged value.
- R8: Output bits whose enable is 0 never change on either event.
- R9: A host write takes effect from the next cycle. An event in the same cycle as the write uses the old register contents.
- R10: A pin changes exactly one clock after the event, or the polarity write, that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_we | input | 1 | Write strobe for the staged pattern |
| stage_wdata | input | 4 | Staged output pattern |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 4 | Per-bit enable, 1 = bit follows events |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | 0 = normal, 1 = non-overlapping |
| pol_we | input | 1 | Write strobe for the polarity bit |
| pol_wdata | input | 1 | 1 = direct, 0 = inverted |
| evt_a | input | 1 | Timer event A strobe |
| evt_b | input | 1 | Timer event B strobe |
| pulse_pins | output | 4 | Registered pin outputs |

## Verification
The vector table changes the staged pattern, the mask, the mode and the polarity together. This shows apart an event that copies the whole pattern, one that only clears, and one that only sets. Event B alone in normal mode and event A alone in non-overlapping mode show that a bit with staged value 1 is not raised early. Partial masks show that masked bits hold their value. Directed cases cover the following: a write in the same cycle as an event, the one-cycle pin latency for both events and polarity, and a reset in mid-run.

// File: rtl/ppg_grp_pkg.sv
package ppg_grp_pkg;
    typedef enum logic {
        XFER_NORMAL = 1'b0,
        XFER_NONOVL = 1'b1
    } xfer_mode_e;
endpackage

// File: rtl/ppg_cfg_regs.sv
module ppg_cfg_regs
    import ppg_grp_pkg::*;
#(
    parameter int GROUP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stage_we,
    input  logic [GROUP_W-1:0] stage_wdata,
    input  logic               mask_we,
    input  logic [GROUP_W-1:0] mask_wdata,
    input  logic               mode_we,
    input  logic               mode_wdata,
    input  logic               pol_we,
    input  logic               pol_wdata,
    output logic [GROUP_W-1:0] stage_q,
    output logic [GROUP_W-1:0] mask_q,
    output xfer_mode_e         mode_q,
    output logic               pol_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            mask_q  <= '0;
            mode_q  <= XFER_NORMAL;
            pol_q   <= 1'b1;
        end else begin
            if (stage_we) stage_q <= stage_wdata;
            if (mask_we)  mask_q  <= mask_wdata;
            if (mode_we)  mode_q  <= xfer_mode_e'(mode_wdata);
            if (pol_we)   pol_q   <= pol_wdata;
        end
    end

    // R9
    stage_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_we |=> (stage_q == $past(stage_wdata)));
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_q));
endmodule

// File: rtl/ppg_xfer.sv
module ppg_xfer
    import ppg_grp_pkg::*;
#(
    parameter int GROUP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  xfer_mode_e         mode,
    input  logic [GROUP_W-1:0] stage,
    input  logic [GROUP_W-1:0] mask,
    input  logic               evt_a,
    input  logic               evt_b,
    output logic [GROUP_W-1:0] odr_q
);
    logic [GROUP_W-1:0] odr_nxt;

    for (genvar i = 0; i < GROUP_W; i++) begin : g_lane
        logic lane_nxt;
        always_comb begin
            lane_nxt = odr_q[i];
            unique case (mode)
                XFER_NORMAL: begin
                    if (mask[i] && evt_a) lane_nxt = stage[i];
                end
                XFER_NONOVL: begin
                    if (mask[i] && evt_a && !stage[i]) lane_nxt = 1'b0;
                    if (mask[i] && evt_b &&  stage[i]) lane_nxt = 1'b1;
                end
            endcase
        end
        assign odr_nxt[i] = lane_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) odr_q <= '0;
        else        odr_q <= odr_nxt;
    end

    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((odr_q & ~$past(mask)) == ($past(odr_q) & ~$past(mask))));
    // R4
    normal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_NORMAL && !evt_a) |=> $stable(odr_q));
    // R5
    nov_a_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_NONOVL && !evt_b) |=> ((odr_q & ~$past(odr_q)) == '0));
    // R6
    nov_b_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_NONOVL && !evt_a) |=> ((~odr_q & $past(odr_q)) == '0));
    // R7
    nov_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XFER_NONOVL && evt_a && evt_b) |=>
            ((odr_q & $past(mask)) == ($past(stage) & $past(mask))));
endmodule

// File: rtl/ppg_pin_drv.sv
module ppg_pin_drv #(
    parameter int GROUP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] odr,
    input  logic               pol,
    output logic [GROUP_W-1:0] pins_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   pins_q <= '0;
        else if (pol) pins_q <= odr;
        else          pins_q <= ~odr;
    end

    // R2
    direct_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol |=> (pins_q == $past(odr)));
    // R3
    inverted_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pol |=> (pins_q == ~$past(odr)));
endmodule

// File: rtl/ppg_nov_group.sv
module ppg_nov_group
    import ppg_grp_pkg::*;
#(
    parameter int GROUP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stage_we,
    input  logic [GROUP_W-1:0] stage_wdata,
    input  logic               mask_we,
    input  logic [GROUP_W-1:0] mask_wdata,
    input  logic               mode_we,
    input  logic               mode_wdata,
    input  logic               pol_we,
    input  logic               pol_wdata,
    input  logic               evt_a,
    input  logic               evt_b,
    output logic [GROUP_W-1:0] pulse_pins
);
    logic [GROUP_W-1:0] stage_q;
    logic [GROUP_W-1:0] mask_q;
    xfer_mode_e         mode_q;
    logic               pol_q;
    logic [GROUP_W-1:0] odr_q;

    ppg_cfg_regs #(.GROUP_W(GROUP_W)) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .stage_we(stage_we), .stage_wdata(stage_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .pol_we(pol_we), .pol_wdata(pol_wdata),
        .stage_q(stage_q), .mask_q(mask_q), .mode_q(mode_q), .pol_q(pol_q)
    );

    ppg_xfer #(.GROUP_W(GROUP_W)) i_xfer (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .stage(stage_q),
        .mask(mask_q), .evt_a(evt_a), .evt_b(evt_b), .odr_q(odr_q)
    );

    ppg_pin_drv #(.GROUP_W(GROUP_W)) i_pins (
        .clk(clk), .rst_n(rst_n), .odr(odr_q), .pol(pol_q), .pins_q(pulse_pins)
    );

    // R1
    reset_exit_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pulse_pins == '0 && mode_q == XFER_NORMAL && pol_q));
endmodule

// File: tb/test_ppg_nov_group.sv
module test_ppg_nov_group;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stage_we = 0, mask_we = 0, mode_we = 0, pol_we = 0;
    logic [W-1:0] stage_wdata = '0, mask_wdata = '0;
    logic         mode_wdata = 0, pol_wdata = 0;
    logic         evt_a = 0, evt_b = 0;
    logic [W-1:0] pulse_pins;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ppg_nov_group #(.GROUP_W(W)) i_ppg_nov_group (
        .clk(clk), .rst_n(rst_n),
        .stage_we(stage_we), .stage_wdata(stage_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .pol_we(pol_we), .pol_wdata(pol_wdata),
        .evt_a(evt_a), .evt_b(evt_b), .pulse_pins(pulse_pins)
    );

    // vector: stage, mask, mode, pol, evt_a, evt_b, expected pins
    typedef struct packed {
        logic [3:0] stage;
        logic [3:0] mask;
        logic       mode;
        logic       pol;
        logic       a;
        logic       b;
        logic [3:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'b1010, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010}, // R4 R2 copy on A
        '{4'b0101, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1010}, // R4 B ignored in normal
        '{4'b0101, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1001}, // R8 partial mask
        '{4'b0101, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110}, // R3 inversion
        '{4'b0011, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0001}, // R5 A clears only
        '{4'b0011, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0011}, // R6 B sets only
        '{4'b1100, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1100}, // R7 both at once
        '{4'b0011, 4'b0101, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1101}, // R6 R8 masked set
        '{4'b0000, 4'b1010, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010}  // R5 R3 masked clear
    };

    task automatic check(input logic [W-1:0] exp, input string req);
        tests++;
        if (pulse_pins !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, pulse_pins, exp);
        end
    endtask

    task automatic write_all(input logic [3:0] s, input logic [3:0] m,
                             input logic md, input logic p);
        @(negedge clk);
        stage_we = 1; stage_wdata = s; mask_we = 1; mask_wdata = m;
        mode_we = 1; mode_wdata = md; pol_we = 1; pol_wdata = p;
        @(negedge clk);
        stage_we = 0; mask_we = 0; mode_we = 0; pol_we = 0;
    endtask

    task automatic strobe(input logic a, input logic b);
        evt_a = a; evt_b = b;
        @(negedge clk);
        evt_a = 0; evt_b = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(4'b0000, "R1 reset pins");
        rst_n = 1;
        @(negedge clk);
        // R1: normal mode after reset, so event B alone does nothing
        @(negedge clk);
        stage_we = 1; stage_wdata = 4'b1111; mask_we = 1; mask_wdata = 4'b1111;
        @(negedge clk);
        stage_we = 0; mask_we = 0;
        strobe(1'b0, 1'b1);
        check(4'b0000, "R1 default normal mode");
        strobe(1'b1, 1'b0);
        check(4'b1111, "R1 default direct polarity");

        // R9: write in the same cycle as the event uses the old staged value
        stage_we = 1; stage_wdata = 4'b0000; evt_a = 1;
        @(negedge clk);
        stage_we = 0; evt_a = 0;
        @(negedge clk);
        check(4'b1111, "R9 same-cycle write uses old data");
        strobe(1'b1, 1'b0);
        check(4'b0000, "R9 new data used next event");

        // R10: pin latency after an event
        stage_we = 1; stage_wdata = 4'b0110;
        @(negedge clk);
        stage_we = 0;
        evt_a = 1;
        @(negedge clk);
        evt_a = 0;
        check(4'b0000, "R10 pins not yet changed");
        @(negedge clk);
        check(4'b0110, "R10 pins one clock after event");

        // R10: pin latency after a polarity write
        pol_we = 1; pol_wdata = 0;
        @(negedge clk);
        pol_we = 0;
        check(4'b0110, "R10 polarity not yet applied");
        @(negedge clk);
        check(4'b1001, "R10 polarity one clock later");

        // vector table, starting from a clean reset
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(4'b0000, "R1 reset in mid-run");
        rst_n = 1;
        for (int v = 0; v < NV; v++) begin
            write_all(VECS[v].stage, VECS[v].mask, VECS[v].mode, VECS[v].pol);
            strobe(VECS[v].a, VECS[v].b);
            check(VECS[v].exp, $sformatf("vector %0d (R2-R8 table)", v));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule